// File: doc/BRIEF.md
# Reset Cause Capture Controller

This block merges a set of reset requests into a single system reset output and remembers which of them started the most recent reset. The requests are a reset pin, brown-out flags for three supplies (VDDS, VDD, VDDR), a clock-loss flag and a software cold-reset bit. The asynchronous active-low `rst_ni` acts as the power-on input. Each supply brown-out passes only when its enable bit is set or its override input is high. Clock loss passes only when its enable bit is set. The pin and software requests always pass.

The first source seen while capture is armed is latched as a 3-bit cause code. That code becomes visible in the readable register only after every source has been released and a one-cycle copy step has run. Capture then rearms. A request that arrives during the copy cycle is recorded as power-on, whatever its real cause. Two sticky wakeup-from-shutdown flags are kept in the same register. One flag records any wakeup, the other records IO-event wakeups only. Software reads and writes everything through a single 32-bit register port, and the read data is combinational.

Top module: `reset_cause_ctrl`

## Requirements
- R1: While `rst_ni` is low, `sys_rst_o` is 1, the cause field reads 0 (power-on), the four enable bits read 1 and both wakeup flags read 0. After `rst_ni` rises, `sys_rst_o` stays high for exactly 4 more rising clock edges.
- R2: A register write with bit 31 set drives `sys_rst_o` high in the cycle after the write edge. The cause becomes 6 (software) once the reset ends. Bit 31 always reads 0. Writing 0 to bit 31 has no effect.
- R3: A supply brown-out causes a reset only when its enable bit or its override input is 1. The enable bits are bit 8 for VDDS, bit 7 for VDDR and bit 6 for VDD. The cause codes are 2 for VDDS, 3 for VDD and 4 for VDDR. A brown-out that is not enabled and not overridden leaves `sys_rst_o` and the cause unchanged.
- R4: Clock loss causes a reset with cause 5 only when bit 5 is 1. When bit 5 is 0, clock loss leaves `sys_rst_o` and the cause unchanged.
- R5: The reset pin always causes a reset, with cause 1. When sources start in the same cycle, the lowest code is recorded. A source that starts while an earlier source is still being held does not change the recorded cause.
- R6: The cause field (bits 3:1) does not change while sources stay active. It takes the new code on the second rising edge after the last source is released.
- R7: If an enabled source becomes active during the copy cycle, the previous cause is copied out first, and power-on (0) is then recorded for the new reset. A source that starts after the copy cycle is recorded with its own code.
- R8: `sys_rst_o` is 1 in any cycle where an enabled source is active. It stays 1 for exactly 4 rising edges after the last source is released.
- R9: Bit 15 sets on `io_wake_i` or `dbg_wake_i`. Bit 14 sets only on `io_wake_i`. Both flags are sticky, and register writes do not change them.
- R10: `pad_sleep_dis_i` clears both wakeup flags on the next edge. The clear takes priority over a set in the same cycle.
- R11: Every bit other than 15, 14, 8, 7, 6, 5 and 3:1 reads 0, and writes to those bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow always-on clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| reset_pin_i | input | 1 | External reset pin request |
| bod_vdds_i | input | 1 | VDDS brown-out flag |
| bod_vddr_i | input | 1 | VDDR brown-out flag |
| bod_vdd_i | input | 1 | VDD brown-out flag |
| ovr_vdds_i | input | 1 | Forces the VDDS brown-out to be honoured |
| ovr_vddr_i | input | 1 | Forces the VDDR brown-out to be honoured |
| ovr_vdd_i | input | 1 | Forces the VDD brown-out to be honoured |
| clk_loss_i | input | 1 | Clock-loss flag |
| io_wake_i | input | 1 | Wakeup from shutdown caused by an IO event |
| dbg_wake_i | input | 1 | Wakeup from shutdown forced by a debugger |
| pad_sleep_dis_i | input | 1 | Clears both wakeup flags |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| sys_rst_o | output | 1 | System reset request |

## Verification
Each gated source is tried with every combination of its enable bit and override. This separates sources that are honoured from sources that are ignored, and a wrong bit position or wrong cause code shows up directly. All pairs of sources that start together are swept, which checks the lowest-code rule. A late higher-priority source added on top of a held one shows that capture follows first-seen order. A second reset placed exactly in the copy cycle is compared with one placed just after it. The first must read as power-on and the second with its own code, which pins down the rearm timing. The stretch length is counted in edges after power-on and after each release. Wakeup inputs are applied alone, together, and together with the clear, to separate the two flags and the clear priority.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned CAUSE_W = 3;
  localparam int unsigned NUM_SRC = 7;
  localparam int unsigned NUM_SUP = 3;

  localparam logic [CAUSE_W-1:0] CAUSE_POR  = 3'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_PIN  = 3'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_VDDS = 3'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_VDD  = 3'd3;
  localparam logic [CAUSE_W-1:0] CAUSE_VDDR = 3'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_CLK  = 3'd5;
  localparam logic [CAUSE_W-1:0] CAUSE_SW   = 3'd6;

  localparam int unsigned BIT_SW      = 31;
  localparam int unsigned BIT_WU      = 15;
  localparam int unsigned BIT_GPIO_WU = 14;
  localparam int unsigned BIT_EN_VDDS = 8;
  localparam int unsigned BIT_EN_VDDR = 7;
  localparam int unsigned BIT_EN_VDD  = 6;
  localparam int unsigned BIT_EN_CLK  = 5;
  localparam int unsigned CAUSE_LSB   = 1;

  typedef enum logic [1:0] {
    CAP_ARMED = 2'd0,
    CAP_HELD  = 2'd1,
    CAP_COPY  = 2'd2
  } cap_state_e;
endpackage

// File: rtl/rcc_src_gate.sv
module rcc_src_gate
  import rcc_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  parameter int unsigned N_SUP = NUM_SUP
) (
  input  logic             pin_i,
  input  logic [N_SUP-1:0] bod_i,      // ordered by cause code: vdds, vdd, vddr
  input  logic [N_SUP-1:0] ovr_i,
  input  logic [N_SUP-1:0] en_sup_i,
  input  logic             clk_loss_i,
  input  logic             en_clk_i,
  input  logic             sw_req_i,
  output logic [N_SRC-1:0] req_o,
  output logic             any_o
);
  localparam int unsigned SUP_BASE = 2;

  assign req_o[0] = 1'b0;  // power-on comes from rst_ni
  assign req_o[1] = pin_i;

  for (genvar g = 0; g < N_SUP; g++) begin : g_sup
    assign req_o[SUP_BASE+g] = bod_i[g] & (en_sup_i[g] | ovr_i[g]);
  end

  assign req_o[SUP_BASE+N_SUP]   = clk_loss_i & en_clk_i;
  assign req_o[SUP_BASE+N_SUP+1] = sw_req_i;

  assign any_o = |req_o;
endmodule

// File: rtl/rcc_cause_capture.sv
module rcc_cause_capture
  import rcc_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  parameter int unsigned C_W   = CAUSE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic             any_i,
  output logic [C_W-1:0]   cause_o
);
  cap_state_e     state_q;
  logic [C_W-1:0] cap_q, cause_q, enc;

  // lowest active code wins
  always_comb begin
    enc = CAUSE_POR;
    for (int k = N_SRC - 1; k >= 1; k--) begin
      if (req_i[k]) enc = C_W'(k);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CAP_ARMED;
      cap_q   <= CAUSE_POR;
      cause_q <= CAUSE_POR;
    end else begin
      unique case (state_q)
        CAP_ARMED: begin
          if (any_i) begin
            cap_q   <= enc;
            state_q <= CAP_HELD;
          end
        end
        CAP_HELD: begin
          if (!any_i) state_q <= CAP_COPY;
        end
        CAP_COPY: begin
          cause_q <= cap_q;
          if (any_i) begin
            cap_q   <= CAUSE_POR;  // not yet rearmed
            state_q <= CAP_HELD;
          end else begin
            state_q <= CAP_ARMED;
          end
        end
        default: state_q <= CAP_ARMED;
      endcase
    end
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/rcc_rst_stretch.sv
module rcc_rst_stretch #(
  parameter int unsigned STRETCH_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_i,
  output logic sys_rst_o
);
  localparam int unsigned CNT_W = $clog2(STRETCH_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STRETCH_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= CNT_MAX;
    else if (any_i)              cnt_q <= CNT_MAX;
    else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  assign sys_rst_o = any_i | (cnt_q != '0);
endmodule

// File: rtl/rcc_regs.sv
module rcc_regs
  import rcc_pkg::*;
#(
  parameter int unsigned D_W = DATA_W,
  parameter int unsigned C_W = CAUSE_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [D_W-1:0] wdata_i,
  input  logic [C_W-1:0] cause_i,
  input  logic           io_wake_i,
  input  logic           dbg_wake_i,
  input  logic           pad_sleep_dis_i,
  output logic [2:0]     en_sup_o,   // vdds, vdd, vddr
  output logic           en_clk_o,
  output logic           sw_req_o,
  output logic [D_W-1:0] rdata_o
);
  logic en_vdds_q, en_vddr_q, en_vdd_q, en_clk_q;
  logic sw_q, wu_q, gpio_wu_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_vdds_q <= 1'b1;
      en_vddr_q <= 1'b1;
      en_vdd_q  <= 1'b1;
      en_clk_q  <= 1'b1;
      sw_q      <= 1'b0;
    end else begin
      sw_q <= we_i & wdata_i[BIT_SW];  // self-clearing
      if (we_i) begin
        en_vdds_q <= wdata_i[BIT_EN_VDDS];
        en_vddr_q <= wdata_i[BIT_EN_VDDR];
        en_vdd_q  <= wdata_i[BIT_EN_VDD];
        en_clk_q  <= wdata_i[BIT_EN_CLK];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wu_q      <= 1'b0;
      gpio_wu_q <= 1'b0;
    end else if (pad_sleep_dis_i) begin
      wu_q      <= 1'b0;
      gpio_wu_q <= 1'b0;
    end else begin
      if (io_wake_i | dbg_wake_i) wu_q      <= 1'b1;
      if (io_wake_i)              gpio_wu_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o                          = '0;
    rdata_o[BIT_WU]                  = wu_q;
    rdata_o[BIT_GPIO_WU]             = gpio_wu_q;
    rdata_o[BIT_EN_VDDS]             = en_vdds_q;
    rdata_o[BIT_EN_VDDR]             = en_vddr_q;
    rdata_o[BIT_EN_VDD]              = en_vdd_q;
    rdata_o[BIT_EN_CLK]              = en_clk_q;
    rdata_o[CAUSE_LSB +: C_W]        = cause_i;
  end

  assign en_sup_o = {en_vddr_q, en_vdd_q, en_vdds_q};
  assign en_clk_o = en_clk_q;
  assign sw_req_o = sw_q;
endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl
  import rcc_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reset_pin_i,
  input  logic              bod_vdds_i,
  input  logic              bod_vddr_i,
  input  logic              bod_vdd_i,
  input  logic              ovr_vdds_i,
  input  logic              ovr_vddr_i,
  input  logic              ovr_vdd_i,
  input  logic              clk_loss_i,
  input  logic              io_wake_i,
  input  logic              dbg_wake_i,
  input  logic              pad_sleep_dis_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              sys_rst_o
);
  logic [NUM_SRC-1:0] req;
  logic               req_any;
  logic [NUM_SUP-1:0] en_sup;
  logic               en_clk, sw_req;
  logic [CAUSE_W-1:0] cause;

  rcc_regs #(.D_W(DATA_W), .C_W(CAUSE_W)) i_regs (
    .clk_i, .rst_ni,
    .we_i           (reg_we_i),
    .wdata_i        (reg_wdata_i),
    .cause_i        (cause),
    .io_wake_i,
    .dbg_wake_i,
    .pad_sleep_dis_i,
    .en_sup_o       (en_sup),
    .en_clk_o       (en_clk),
    .sw_req_o       (sw_req),
    .rdata_o        (reg_rdata_o)
  );

  rcc_src_gate #(.N_SRC(NUM_SRC), .N_SUP(NUM_SUP)) i_gate (
    .pin_i      (reset_pin_i),
    .bod_i      ({bod_vddr_i, bod_vdd_i, bod_vdds_i}),
    .ovr_i      ({ovr_vddr_i, ovr_vdd_i, ovr_vdds_i}),
    .en_sup_i   (en_sup),
    .clk_loss_i,
    .en_clk_i   (en_clk),
    .sw_req_i   (sw_req),
    .req_o      (req),
    .any_o      (req_any)
  );

  rcc_cause_capture #(.N_SRC(NUM_SRC), .C_W(CAUSE_W)) i_cap (
    .clk_i, .rst_ni,
    .req_i   (req),
    .any_i   (req_any),
    .cause_o (cause)
  );

  rcc_rst_stretch #(.STRETCH_CYC(STRETCH_CYC)) i_stretch (
    .clk_i, .rst_ni,
    .any_i     (req_any),
    .sys_rst_o
  );
endmodule

// File: rtl/reset_cause_ctrl_chk.sv
module reset_cause_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reset_pin_i,
  input logic        bod_vdds_i,
  input logic        ovr_vdds_i,
  input logic        clk_loss_i,
  input logic        pad_sleep_dis_i,
  input logic        reg_we_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic        sys_rst_o,
  input logic        req_any
);
  a_r5_pin_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_pin_i |-> sys_rst_o);

  a_r3_vdds_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bod_vdds_i && (reg_rdata_o[8] || ovr_vdds_i)) |-> sys_rst_o);

  a_r4_clk_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_loss_i && reg_rdata_o[5]) |-> sys_rst_o);

  a_r2_sw_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_wdata_i[31]) |=> sys_rst_o);

  a_r8_hold_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_any) |-> sys_rst_o);

  a_r6_cause_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_any && $past(req_any) && $past(req_any, 2)) |-> $stable(reg_rdata_o[3:1]));

  a_r9_gpio_implies_wu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[14] |-> reg_rdata_o[15]);

  a_r10_flags_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_sleep_dis_i |=> (!reg_rdata_o[15] && !reg_rdata_o[14]));
endmodule

bind reset_cause_ctrl reset_cause_ctrl_chk i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .reset_pin_i     (reset_pin_i),
  .bod_vdds_i      (bod_vdds_i),
  .ovr_vdds_i      (ovr_vdds_i),
  .clk_loss_i      (clk_loss_i),
  .pad_sleep_dis_i (pad_sleep_dis_i),
  .reg_we_i        (reg_we_i),
  .reg_wdata_i     (reg_wdata_i),
  .reg_rdata_o     (reg_rdata_o),
  .sys_rst_o       (sys_rst_o),
  .req_any         (req_any)
);

// File: tb/test_reset_cause_ctrl.sv
module test_reset_cause_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pin = 0, b_vdds = 0, b_vddr = 0, b_vdd = 0;
  logic        o_vdds = 0, o_vddr = 0, o_vdd = 0, cl = 0;
  logic        io_w = 0, dbg_w = 0, psd = 0, we = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sys_rst;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] en_m = 4'hF;  // {vdds, vddr, vdd, clk} = bits 8..5
  logic [2:0] cause_m = 3'd0;
  logic       wu_m = 0, gpio_m = 0;

  always #5 clk = ~clk;

  reset_cause_ctrl i_reset_cause_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .reset_pin_i(pin),
    .bod_vdds_i(b_vdds), .bod_vddr_i(b_vddr), .bod_vdd_i(b_vdd),
    .ovr_vdds_i(o_vdds), .ovr_vddr_i(o_vddr), .ovr_vdd_i(o_vdd),
    .clk_loss_i(cl), .io_wake_i(io_w), .dbg_wake_i(dbg_w),
    .pad_sleep_dis_i(psd), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .sys_rst_o(sys_rst)
  );

  function automatic logic [31:0] exp_rd();
    return (32'(wu_m) << 15) | (32'(gpio_m) << 14) | (32'(en_m) << 5) | (32'(cause_m) << 1);
  endfunction

  function automatic int en_idx(int s);
    case (s)
      2: return 3;
      3: return 1;
      4: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [31:0] d);
    we = 1'b1; wdata = d;
    cyc(1);
    we = 1'b0; wdata = '0;
    en_m = {d[8], d[7], d[6], d[5]};
    #1;
  endtask

  task automatic set_src(int s, logic v);
    case (s)
      1: pin = v;
      2: b_vdds = v;
      3: b_vdd = v;
      4: b_vddr = v;
      default: cl = v;
    endcase
  endtask

  task automatic set_ovr(int s, logic v);
    case (s)
      2: o_vdds = v;
      3: o_vdd = v;
      4: o_vddr = v;
      default: ;
    endcase
  endtask

  // counts edges sys_rst stays high after the moment of release
  task automatic stretch_chk(string tag);
    int n = 0;
    #1;
    while (sys_rst && n < 20) begin
      n++;
      cyc(1);
    end
    chk(tag, 32'(n), 32'd4);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 power-on state and stretch
    cyc(3);
    chk("R1 sys_rst in reset", 32'(sys_rst), 32'd1);
    chk("R1 reset readback", rdata, 32'h0000_01E0);
    rst_ni = 1'b1;
    stretch_chk("R1 stretch after power-on");
    chk("R1 readback after power-on", rdata, exp_rd());

    // R3/R4 gating sweep over enable and override
    for (int s = 2; s <= 5; s++) begin
      for (int m = 0; m < 4; m++) begin
        logic [3:0] e;
        logic hit;
        string tag;
        if (s == 5 && m > 1) continue;
        tag = (s == 5) ? "R4" : "R3";
        e = 4'hF; e[en_idx(s)] = m[0];
        wr(32'(e) << 5);
        set_src(s, 1'b1); set_ovr(s, m[1]);
        cyc(2);
        hit = m[0] | m[1];
        chk({tag, " gated reset"}, 32'(sys_rst), 32'(hit));
        set_src(s, 1'b0);
        if (hit) begin
          stretch_chk({tag, " stretch R8"});
          cyc(4);
          cause_m = 3'(s);
        end else begin
          cyc(1);
          chk({tag, " ignored no reset"}, 32'(sys_rst), 32'd0);
        end
        set_ovr(s, 1'b0);
        chk({tag, " cause readback"}, rdata, exp_rd());
      end
    end
    wr(32'h0000_01E0);

    // R5 pin with all enables cleared
    wr(32'h0);
    set_src(1, 1'b1); cyc(2);
    chk("R5 pin resets", 32'(sys_rst), 32'd1);
    set_src(1, 1'b0);
    stretch_chk("R8 stretch after pin");
    cyc(4); cause_m = 3'd1;
    chk("R5 pin cause", rdata, exp_rd());
    wr(32'h0000_01E0);

    // R5 simultaneous pairs: lowest code
    for (int a = 1; a <= 5; a++) begin
      for (int b = a + 1; b <= 5; b++) begin
        set_src(a, 1'b1); set_src(b, 1'b1);
        cyc(2);
        set_src(a, 1'b0); set_src(b, 1'b0);
        cyc(8);
        cause_m = 3'(a);
        chk("R5 simultaneous lowest code", rdata, exp_rd());
      end
    end

    // R5 first-seen beats lower code; R6 cause frozen while held
    set_src(5, 1'b1); cyc(2);
    set_src(1, 1'b1); cyc(3);
    chk("R6 cause frozen while active", rdata, exp_rd());
    set_src(5, 1'b0); cyc(3);
    chk("R6 cause frozen second source", rdata, exp_rd());
    set_src(1, 1'b0); cyc(1);
    chk("R6 not yet copied", rdata, exp_rd());
    cyc(1);
    cause_m = 3'd5;
    chk("R6 copied on second edge / R5 first seen", rdata, exp_rd());
    cyc(6);

    // R7 reset inside copy cycle reads as power-on
    set_src(1, 1'b1); cyc(2); set_src(1, 1'b0);
    cyc(1);
    set_src(2, 1'b1); cyc(3);
    cause_m = 3'd1;
    chk("R7 previous cause copied", rdata, exp_rd());
    set_src(2, 1'b0); cyc(8);
    cause_m = 3'd0;
    chk("R7 copy-window reset is power-on", rdata, exp_rd());

    // R7 contrast: after rearm true cause kept
    set_src(1, 1'b1); cyc(2); set_src(1, 1'b0);
    cyc(3);
    set_src(2, 1'b1); cyc(3);
    set_src(2, 1'b0); cyc(8);
    cause_m = 3'd2;
    chk("R7 rearmed reset keeps code", rdata, exp_rd());

    // R2 software reset
    wr(32'h8000_01E0);
    chk("R2 sw write asserts reset", 32'(sys_rst), 32'd1);
    chk("R2 bit31 reads 0", 32'(rdata[31]), 32'd0);
    cyc(12);
    chk("R2 reset released", 32'(sys_rst), 32'd0);
    cause_m = 3'd6;
    chk("R2 sw cause", rdata, exp_rd());
    set_src(3, 1'b1); cyc(2); set_src(3, 1'b0); cyc(8);
    cause_m = 3'd3;
    wr(32'h0000_01E0);
    cyc(1);
    chk("R2 write 0 no reset", 32'(sys_rst), 32'd0);
    cyc(6);
    chk("R2 write 0 cause kept", rdata, exp_rd());

    // R11 reserved bits
    wr(32'h7FFF_FE1F);
    cyc(6);
    chk("R11 reserved ignored", rdata, exp_rd());
    chk("R11 reserved read 0", rdata & ~32'h0000_C1EE, 32'h0);
    wr(32'h0000_01E0);

    // R9/R10 wakeup flags
    io_w = 1'b1; cyc(1); io_w = 1'b0;
    wu_m = 1; gpio_m = 1;
    chk("R9 io wake sets both", rdata, exp_rd());
    wr(32'h0000_01E0);
    chk("R9 write leaves flags", rdata, exp_rd());
    psd = 1'b1; cyc(1); psd = 1'b0;
    wu_m = 0; gpio_m = 0;
    chk("R10 clear both", rdata, exp_rd());
    dbg_w = 1'b1; cyc(1); dbg_w = 1'b0;
    wu_m = 1;
    chk("R9 debug wake sets bit15 only", rdata, exp_rd());
    io_w = 1'b1; psd = 1'b1; cyc(1); io_w = 1'b0; psd = 1'b0;
    wu_m = 0;
    chk("R10 clear beats set", rdata, exp_rd());

    // R1 power-on restores defaults
    wr(32'h0);
    set_src(4, 1'b1); cyc(2); set_src(4, 1'b0); cyc(8);
    io_w = 1'b1; cyc(1); io_w = 1'b0;
    rst_ni = 1'b0; cyc(2);
    en_m = 4'hF; cause_m = 3'd0; wu_m = 0; gpio_m = 0;
    chk("R1 second power-on readback", rdata, exp_rd());
    rst_ni = 1'b1;
    stretch_chk("R1 second power-on stretch");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule